// File: doc/BRIEF.md
# Fine-Tuned Nanosecond Time Counter

This block keeps the local time of a precision-time-protocol clock as a nanosecond count. On every cycle in which counting is enabled the count advances by a programmable step. Once in every programmable number of cycles a second step value is used in its place. Software sets that second step slightly above or below the normal one, which trims the clock's rate without touching the clock source.

The count can be made to roll over at a programmable modulus, so that it forms a bounded time base, for example 31 bits when the modulus is 2^31. Each rollover produces a one-cycle pulse for neighbouring compare logic. A small memory-mapped read/write port gives software four operations: take a coherent snapshot of the running count, read that snapshot back, overwrite the count directly, and program every setting. The live count is also driven out for neighbouring logic.

Register map, by word address: 0 control, 1 time, 2 modulus, 3 correction interval, 4 step. Any other address reads zero.

Top module: `ptp_fine_counter`

## Requirements
- R1: After reset the live count, the rollover pulse and the read data are zero, and every register reads back zero.
- R2: While control bit 0 (run) is 0, the live count holds its value unless software writes the time register.
- R3: While running, with no correction due and no rollover, the count grows by the normal step each cycle. The normal step is held in step register bits [6:0].
- R4: When the correction interval register holds P not equal to 0, the correction step (step register bits [14:8]) is used in place of the normal step on every (P+1)-th running cycle. When P is 0, no correction is ever applied.
- R5: A write to the correction-interval register restarts its cycle count, so the next correction falls P+1 running cycles after that write.
- R6: Rollover is enabled when control bits [5:4] are not both zero and the modulus is not zero. If the new count would be greater than or equal to the modulus, the modulus is subtracted from it. With rollover disabled, the count wraps naturally at 2^32.
- R7: `wrap_pulse` is high for exactly the cycle in which the rolled-over count is first visible on `cur_time`, and is low in every other cycle.
- R8: Writing the control register with bit 11 set latches the count present before that clock edge. A read of the time register issued on the very next cycle returns that value. Bit 11 always reads back 0.
- R9: A write to the time register loads the written value into the count at that edge. The load takes priority over any increment due in that cycle.
- R10: Registers read back what was written. Control reads only bits 0, 4 and 5. Step reads only bits [6:0] and [14:8]. Addresses 5 to 7 read 0.
- R11: `rdata` is registered: it takes the selected register one cycle after `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cur_time | output | 32 | Live nanosecond count |
| wrap_pulse | output | 1 | One-cycle rollover pulse |

## Verification
The assertions take for granted that a write and a read never target the time register in the same cycle with conflicting intent. They also take for granted that the bus strobes are clean binary levels once reset is released. The step-growth property holds only when no rollover is enabled, so it is gated on the control bits. The stimulus keeps to these assumptions by issuing one register operation per cycle, drawn at random. It keeps the modulus small enough that rollovers happen often, and draws correction intervals small enough that corrections happen often. Directed sequences then place loads just below the modulus and at the top of the 32-bit range.

// File: rtl/ptp_cnt_pkg.sv
package ptp_cnt_pkg;
  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_TIME   = 3'd1,
    RA_MODULO = 3'd2,
    RA_CINT   = 3'd3,
    RA_STEP   = 3'd4
  } reg_addr_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_WRAP_LO  = 4;
  localparam int CTRL_WRAP_HI  = 5;
  localparam int CTRL_SNAP_BIT = 11;
  localparam int STEP_CORR_LSB = 8;
endpackage

// File: rtl/ptp_corr_sched.sv
module ptp_corr_sched #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] interval,
  input  logic          restart,
  output logic          tick
);
  logic [TW-1:0] cyc_q, cyc_d;
  logic          active;

  assign active = run && (interval != '0);

  always_comb begin
    tick  = active && (cyc_q == interval);
    cyc_d = cyc_q;
    if (restart)     cyc_d = '0;
    else if (active) cyc_d = tick ? '0 : cyc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end
endmodule

// File: rtl/ptp_time_acc.sv
module ptp_time_acc #(
  parameter int TW     = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wrap_en,
  input  logic [TW-1:0]     modulus,
  input  logic [STEP_W-1:0] step_norm,
  input  logic [STEP_W-1:0] step_corr,
  input  logic              tick,
  input  logic              load,
  input  logic [TW-1:0]     load_val,
  output logic [TW-1:0]     count,
  output logic              wrap_pulse
);
  localparam int SW = TW + 1;

  logic [TW-1:0] cnt_q, cnt_d;
  logic          pulse_q, pulse_d;
  logic [SW-1:0] sum, reduced;
  logic          hit;

  always_comb begin
    sum     = {1'b0, cnt_q} + SW'(tick ? step_corr : step_norm);
    hit     = wrap_en && (modulus != '0) && (sum >= {1'b0, modulus});
    reduced = sum - {1'b0, modulus};
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (run) begin
      cnt_d   = hit ? reduced[TW-1:0] : sum[TW-1:0];
      pulse_d = hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign count      = cnt_q;
  assign wrap_pulse = pulse_q;
endmodule

// File: rtl/ptp_regs.sv
module ptp_regs
  import ptp_cnt_pkg::*;
#(
  parameter int TW     = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [TW-1:0]     wdata,
  input  logic [TW-1:0]     count,
  output logic [TW-1:0]     rdata,
  output logic              run,
  output logic              wrap_en,
  output logic [TW-1:0]     modulus,
  output logic [TW-1:0]     interval,
  output logic              cint_wr,
  output logic [STEP_W-1:0] step_norm,
  output logic [STEP_W-1:0] step_corr,
  output logic              load,
  output logic [TW-1:0]     snap
);
  localparam int CORR_MSB = STEP_CORR_LSB + STEP_W - 1;

  logic              run_q, run_d;
  logic [1:0]        wmode_q, wmode_d;
  logic [TW-1:0]     mod_q, mod_d, cint_q, cint_d, snap_q, snap_d, rd_q, rd_d;
  logic [STEP_W-1:0] sn_q, sn_d, sc_q, sc_d;
  logic [TW-1:0]     rsel;
  reg_addr_e         ra;

  assign ra = reg_addr_e'(addr);

  always_comb begin
    run_d   = run_q;
    wmode_d = wmode_q;
    mod_d   = mod_q;
    cint_d  = cint_q;
    sn_d    = sn_q;
    sc_d    = sc_q;
    snap_d  = snap_q;
    if (wr_en) begin
      unique case (ra)
        RA_CTRL: begin
          run_d   = wdata[CTRL_RUN_BIT];
          wmode_d = wdata[CTRL_WRAP_HI:CTRL_WRAP_LO];
          if (wdata[CTRL_SNAP_BIT]) snap_d = count;
        end
        RA_MODULO: mod_d  = wdata;
        RA_CINT:   cint_d = wdata;
        RA_STEP: begin
          sn_d = wdata[STEP_W-1:0];
          sc_d = wdata[CORR_MSB:STEP_CORR_LSB];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rsel = '0;
    unique case (ra)
      RA_CTRL: begin
        rsel[CTRL_RUN_BIT]              = run_q;
        rsel[CTRL_WRAP_HI:CTRL_WRAP_LO] = wmode_q;
      end
      RA_TIME:   rsel = snap_q;
      RA_MODULO: rsel = mod_q;
      RA_CINT:   rsel = cint_q;
      RA_STEP: begin
        rsel[STEP_W-1:0]              = sn_q;
        rsel[CORR_MSB:STEP_CORR_LSB]  = sc_q;
      end
      default: rsel = '0;
    endcase
    rd_d = rd_en ? rsel : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      wmode_q <= 2'b00;
      mod_q   <= '0;
      cint_q  <= '0;
      sn_q    <= '0;
      sc_q    <= '0;
      snap_q  <= '0;
      rd_q    <= '0;
    end else begin
      run_q   <= run_d;
      wmode_q <= wmode_d;
      mod_q   <= mod_d;
      cint_q  <= cint_d;
      sn_q    <= sn_d;
      sc_q    <= sc_d;
      snap_q  <= snap_d;
      rd_q    <= rd_d;
    end
  end

  assign rdata     = rd_q;
  assign run       = run_q;
  assign wrap_en   = |wmode_q;
  assign modulus   = mod_q;
  assign interval  = cint_q;
  assign cint_wr   = wr_en && (ra == RA_CINT);
  assign step_norm = sn_q;
  assign step_corr = sc_q;
  assign load      = wr_en && (ra == RA_TIME);
  assign snap      = snap_q;
endmodule

// File: rtl/ptp_fine_counter.sv
module ptp_fine_counter #(
  parameter int TW     = 32,
  parameter int STEP_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] rdata,
  output logic [TW-1:0] cur_time,
  output logic          wrap_pulse
);
  logic              run_w, wrap_en_w, cint_wr_w, load_w, tick_w;
  logic [TW-1:0]     modulus_w, interval_w, snap_w;
  logic [STEP_W-1:0] step_norm_w, step_corr_w;

  ptp_regs #(.TW(TW), .STEP_W(STEP_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .count     (cur_time),
    .rdata     (rdata),
    .run       (run_w),
    .wrap_en   (wrap_en_w),
    .modulus   (modulus_w),
    .interval  (interval_w),
    .cint_wr   (cint_wr_w),
    .step_norm (step_norm_w),
    .step_corr (step_corr_w),
    .load      (load_w),
    .snap      (snap_w)
  );

  ptp_corr_sched #(.TW(TW)) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .interval (interval_w),
    .restart  (cint_wr_w),
    .tick     (tick_w)
  );

  ptp_time_acc #(.TW(TW), .STEP_W(STEP_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_w),
    .wrap_en    (wrap_en_w),
    .modulus    (modulus_w),
    .step_norm  (step_norm_w),
    .step_corr  (step_corr_w),
    .tick       (tick_w),
    .load       (load_w),
    .load_val   (wdata),
    .count      (cur_time),
    .wrap_pulse (wrap_pulse)
  );
endmodule

// File: rtl/ptp_fine_counter_chk.sv
module ptp_fine_counter_chk #(
  parameter int TW     = 32,
  parameter int STEP_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [2:0]        addr,
  input logic [TW-1:0]     wdata,
  input logic [TW-1:0]     rdata,
  input logic [TW-1:0]     cur_time,
  input logic              wrap_pulse,
  input logic              run,
  input logic              wrap_en,
  input logic              tick,
  input logic [STEP_W-1:0] step_norm,
  input logic [TW-1:0]     snap
);
  logic time_wr;
  assign time_wr = wr_en && (addr == 3'd1);

  // R2
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !time_wr) |=> $stable(cur_time));

  // R3
  norm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !time_wr && !tick && !wrap_en && !(wr_en && addr == 3'd0))
      |=> cur_time == $past(cur_time) + TW'($past(step_norm)));

  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> cur_time == $past(wdata));

  // R7
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> ($past(run) && $past(wrap_en) && !$past(time_wr)));

  // R8
  snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && wdata[11]) |=> snap == $past(cur_time));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind ptp_fine_counter ptp_fine_counter_chk #(.TW(TW), .STEP_W(STEP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .cur_time   (cur_time),
  .wrap_pulse (wrap_pulse),
  .run        (run_w),
  .wrap_en    (wrap_en_w),
  .tick       (tick_w),
  .step_norm  (step_norm_w),
  .snap       (snap_w)
);

// File: tb/test_ptp_fine_counter.sv
module test_ptp_fine_counter;
  localparam int TW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [2:0]    addr;
  logic [TW-1:0] wdata, rdata, cur_time;
  logic          wrap_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] m_cnt, m_snap, m_mod, m_cint, m_cyc, m_rd;
  logic        m_run, m_wp;
  logic [1:0]  m_wmode;
  logic [6:0]  m_sn, m_sc;

  always #5 clk = ~clk;

  ptp_fine_counter i_ptp_fine_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cur_time(cur_time), .wrap_pulse(wrap_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_read(input logic [2:0] a);
    case (a)
      3'd0: ref_read = {26'd0, m_wmode, 3'd0, m_run};
      3'd1: ref_read = m_snap;
      3'd2: ref_read = m_mod;
      3'd3: ref_read = m_cint;
      3'd4: ref_read = {17'd0, m_sc, 1'b0, m_sn};
      default: ref_read = 32'd0;
    endcase
  endfunction

  task automatic ref_step(input logic w, input logic r, input logic [2:0] a, input logic [31:0] d);
    logic        tk, hit, act;
    logic [32:0] sum;
    act = m_run && (m_cint != 0);
    tk  = act && (m_cyc == m_cint);
    sum = {1'b0, m_cnt} + 33'(tk ? m_sc : m_sn);
    hit = (m_wmode != 0) && (m_mod != 0) && (sum >= {1'b0, m_mod});
    if (r) m_rd = ref_read(a);
    m_wp = 1'b0;
    if (w && a == 3'd1) m_cnt = d;
    else if (m_run) begin
      m_cnt = hit ? 32'(sum - {1'b0, m_mod}) : sum[31:0];
      m_wp  = hit;
    end
    if (w && a == 3'd3) m_cyc = 0;
    else if (act) m_cyc = tk ? 0 : m_cyc + 1;
    if (w) begin
      case (a)
        3'd0: begin
          if (d[11]) m_snap = sum[31:0] - 32'(tk ? m_sc : m_sn);
          m_run = d[0]; m_wmode = d[5:4];
        end
        3'd2: m_mod = d;
        3'd3: m_cint = d;
        3'd4: begin m_sn = d[6:0]; m_sc = d[14:8]; end
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [2:0] a,
                     input logic [31:0] d, input string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(posedge clk);
    ref_step(w, r, a, d);
    #1;
    check({tag, " time"}, cur_time, m_cnt);
    check({tag, " pulse"}, {31'd0, wrap_pulse}, {31'd0, m_wp});
    check({tag, " rdata"}, rdata, m_rd);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 32'd0, tag);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    m_cnt = 0; m_snap = 0; m_mod = 0; m_cint = 0; m_cyc = 0; m_rd = 0;
    m_run = 0; m_wp = 0; m_wmode = 0; m_sn = 0; m_sc = 0;
    #23;
    check("R1 reset time", cur_time, 32'd0);
    check("R1 reset pulse", {31'd0, wrap_pulse}, 32'd0);
    check("R1 reset rdata", rdata, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 8; a++) cyc(1'b0, 1'b1, 3'(a), 0, "R1 R10 reset readback");

    // R2: program step, stay stopped
    cyc(1'b1, 1'b0, 3'd4, 32'h0000_0908, "R10 step write");
    idle(4, "R2 stopped");
    check("R2 held", cur_time, 32'd0);
    // R3: run, no correction, no rollover
    cyc(1'b1, 1'b0, 3'd0, 32'h1, "R3 run on");
    idle(6, "R3 normal step");
    // R4: correction every 4 cycles
    cyc(1'b1, 1'b0, 3'd3, 32'd3, "R4 interval");
    idle(12, "R4 correction");
    // R5: restart mid-way
    idle(2, "R5 pre");
    cyc(1'b1, 1'b0, 3'd3, 32'd3, "R5 rewrite");
    idle(8, "R5 restarted");
    cyc(1'b1, 1'b0, 3'd3, 32'd0, "R4 interval zero");
    idle(5, "R4 no correction");
    // R6 R7: rollover at 100
    cyc(1'b1, 1'b0, 3'd2, 32'd100, "R6 modulus");
    cyc(1'b1, 1'b0, 3'd1, 32'd90, "R9 load");
    cyc(1'b1, 1'b0, 3'd0, 32'h21, "R6 wrap on");
    idle(30, "R6 R7 rollover");
    cyc(1'b1, 1'b0, 3'd0, 32'h11, "R6 other wrap bit");
    idle(15, "R6 R7 rollover lo");
    // R6: natural 2^32 wrap
    cyc(1'b1, 1'b0, 3'd0, 32'h1, "R6 wrap off");
    cyc(1'b1, 1'b0, 3'd1, 32'hFFFF_FFF0, "R9 load top");
    idle(4, "R6 natural wrap");
    // R8: capture then read next cycle
    cyc(1'b1, 1'b0, 3'd0, 32'h801, "R8 capture");
    cyc(1'b0, 1'b1, 3'd1, 0, "R8 read snap");
    cyc(1'b0, 1'b1, 3'd0, 0, "R8 R10 snap bit reads 0");
    // R10 R11
    cyc(1'b1, 1'b0, 3'd4, 32'hFFFF_FFFF, "R10 step mask");
    cyc(1'b0, 1'b1, 3'd4, 0, "R10 step read");
    idle(3, "R11 hold");
    cyc(1'b0, 1'b1, 3'd6, 0, "R10 unused addr");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int sel;
      sel = $urandom % 16;
      case (sel)
        0: cyc(1'b1, 1'b0, 3'd0, {20'd0, 1'($urandom), 5'd0, 2'($urandom), 3'd0, 1'($urandom % 8 != 0)}, "R2 R8 rnd ctrl");
        1: cyc(1'b1, 1'b0, 3'd1, (sel & 1) ? $urandom : $urandom % 3000, "R9 rnd load");
        2: cyc(1'b1, 1'b0, 3'd2, 50 + $urandom % 3000, "R6 rnd modulus");
        3: cyc(1'b1, 1'b0, 3'd3, $urandom % 8, "R4 R5 rnd interval");
        4: cyc(1'b1, 1'b0, 3'd4, $urandom, "R3 rnd step");
        5, 6: cyc(1'b0, 1'b1, 3'($urandom), 0, "R10 R11 rnd read");
        default: cyc(1'b0, 1'b0, 3'd0, 0, "R3 R4 R6 R7 rnd idle");
      endcase
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule